// File: doc/BRIEF.md
# Interrupt Priority Control Register

This block is a single 32-bit control register that assigns an enable and a priority level to four interrupt sources. One source is an active-low external pin; the other three are two DMA channel requests and one grouped host-port request. Software writes the register as a whole word and reads it back combinationally. Each source gets a 2-bit field, and a nonzero field enables that source at one of three levels. For every source the block drives a pending flag together with the decoded level, for a downstream arbiter to use.

The external pin is brought into the clock domain through a two-flop synchronizer. A mode bit selects how the pin is treated. In level mode the pin is sampled as it is. In edge mode a capture latch remembers a falling transition until the core acknowledges it. A read-only status bit shows the capture latch while the pin is armed for edges, and shows the synchronized pin level at all other times. Masking against the core's current level and generating vectors are left to the arbiter.

Top module: `irq_prio_reg`

## Requirements
- R1: After reset `rd_data` reads 0, and every pending output and every level output is 0.
- R2: Only bits 7:6, bit 8 and bits 21:16 hold written values. Every other bit except bit 11 always reads 0, and writes to those bits are ignored.
- R3: Bit 11 is read-only. Writing 0 or 1 to it has no effect on the value read back.
- R4: Each 2-bit priority code decodes as follows: 00 means disabled (pending 0, level 0); 01, 10 and 11 mean enabled at level 0, 1 and 2. A source's pending output is 1 only when it is enabled and its request is active.
- R5: The priority fields are placed as follows: DMA channel 0 at bits 17:16, DMA channel 1 at bits 19:18, host group at bits 21:20, external pin at bits 7:6. Bit 8 selects the pin mode: 0 is level, 1 is falling edge.
- R6: The external pin passes through two flops. A change on `ext_irq_n` reaches the status bit after the second rising clock edge, and not after the first.
- R7: In edge mode with a nonzero field, a synchronized high-to-low transition sets the capture latch. The latch then drives `ext_pend` = 1 and status = 1, and stays set after the pin returns high.
- R8: An `ext_ack` pulse clears the capture latch in edge mode. In level mode `ext_ack` has no effect on `ext_pend`.
- R9: Clearing the external field to 00, or changing to level mode, clears the capture latch. Re-arming afterwards with the pin high shows no pending request.
- R10: In level mode, `ext_pend` = 1 exactly when the field is nonzero and the synchronized pin is low. The status bit reads 1 when the synchronized pin is low and 0 when it is high, whether or not the source is enabled.
- R11: While the pin is armed for edges, the status bit follows the capture latch and not the pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the whole register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data: stored fields plus the status bit |
| ext_irq_n | input | 1 | External interrupt pin, active low, asynchronous |
| ext_ack | input | 1 | Core acknowledge for the external source |
| dma0_req | input | 1 | DMA channel 0 request |
| dma1_req | input | 1 | DMA channel 1 request |
| host_req | input | 1 | Host-port group request |
| ext_pend | output | 1 | External source pending |
| ext_lvl | output | 2 | External source level |
| dma0_pend | output | 1 | DMA channel 0 pending |
| dma0_lvl | output | 2 | DMA channel 0 level |
| dma1_pend | output | 1 | DMA channel 1 pending |
| dma1_lvl | output | 2 | DMA channel 1 level |
| host_pend | output | 1 | Host group pending |
| host_lvl | output | 2 | Host group level |

## Verification
The hardest state to reach is a capture latch that was set and then cleared by disarming rather than by acknowledge. The only trace it leaves is what happens when the source is armed again. The stimulus sets the latch with a real pin fall and releases the pin. It then writes the field to 00, or switches the mode to level, and afterwards re-arms edge mode with the pin high. A latch that failed to clear would now show as pending. Exact synchronizer latency is checked by moving the pin just after a falling clock edge and reading the status after one rising edge and then after two.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int REG_W        = 32;
  localparam int CODE_W       = 2;
  localparam int LVL_W        = 2;
  localparam int NSRC         = 4;
  localparam int EXT_CODE_LSB = 6;
  localparam int EXT_MODE_BIT = 8;
  localparam int STATUS_BIT   = 11;
  localparam int DMA0_LSB     = 16;
  localparam int DMA1_LSB     = 18;
  localparam int HOST_LSB     = 20;

  // source index order used by the decoder array
  localparam int SRC_EXT  = 0;
  localparam int SRC_DMA0 = 1;
  localparam int SRC_DMA1 = 2;
  localparam int SRC_HOST = 3;

  typedef struct packed {
    logic             en;
    logic [LVL_W-1:0] lvl;
  } prio_t;

  // 00 -> off, otherwise level = code - 1
  function automatic prio_t decode_prio(input logic [CODE_W-1:0] code);
    prio_t p;
    p.en  = |code;
    p.lvl = p.en ? LVL_W'(code - CODE_W'(1)) : '0;
    return p;
  endfunction

  function automatic logic [REG_W-1:0] field_mask(input int lsb, input int w);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] storage_mask();
    return field_mask(EXT_CODE_LSB, CODE_W) | field_mask(EXT_MODE_BIT, 1) |
           field_mask(DMA0_LSB, CODE_W) | field_mask(DMA1_LSB, CODE_W) |
           field_mask(HOST_LSB, CODE_W);
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain_q;

  // idle level of an active-low pin is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], pin_n};
  end

  assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  input  logic armed,
  input  logic ack,
  output logic fall_evt,
  output logic edge_q
);
  logic prev_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_n_q <= 1'b1;
    else        prev_n_q <= sync_n;
  end

  assign fall_evt = prev_n_q & ~sync_n;

  // a fresh edge wins over a simultaneous acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        edge_q <= 1'b0;
    else if (!armed)   edge_q <= 1'b0;
    else if (fall_evt) edge_q <= 1'b1;
    else if (ack)      edge_q <= 1'b0;
  end
endmodule

// File: rtl/irq_src_decode.sv
module irq_src_decode
  import irq_prio_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              req,
  output logic              pend,
  output logic [LVL_W-1:0]  lvl
);
  prio_t p;
  assign p    = decode_prio(code);
  assign pend = p.en & req;
  assign lvl  = p.lvl;
endmodule

// File: rtl/irq_prio_reg.sv
module irq_prio_reg
  import irq_prio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             ext_irq_n,
  input  logic             ext_ack,
  input  logic             dma0_req,
  input  logic             dma1_req,
  input  logic             host_req,
  output logic             ext_pend,
  output logic [LVL_W-1:0] ext_lvl,
  output logic             dma0_pend,
  output logic [LVL_W-1:0] dma0_lvl,
  output logic             dma1_pend,
  output logic [LVL_W-1:0] dma1_lvl,
  output logic             host_pend,
  output logic [LVL_W-1:0] host_lvl
);
  localparam logic [REG_W-1:0] WR_MASK = storage_mask();

  logic [REG_W-1:0] ctrl_q;
  logic             sync_n, fall_evt, edge_q, edge_armed, ext_en, ext_req, status_bit;
  logic [CODE_W-1:0] code_arr [NSRC];
  logic              req_arr  [NSRC];
  logic              pend_arr [NSRC];
  logic [LVL_W-1:0]  lvl_arr  [NSRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data & WR_MASK;
  end

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_irq_n), .sync_n(sync_n)
  );

  assign ext_en     = |ctrl_q[EXT_CODE_LSB +: CODE_W];
  assign edge_armed = ext_en & ctrl_q[EXT_MODE_BIT];

  irq_edge_capture u_cap (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .armed(edge_armed),
    .ack(ext_ack), .fall_evt(fall_evt), .edge_q(edge_q)
  );

  assign status_bit = edge_armed ? edge_q : ~sync_n;
  assign ext_req    = status_bit;

  assign code_arr[SRC_EXT]  = ctrl_q[EXT_CODE_LSB +: CODE_W];
  assign code_arr[SRC_DMA0] = ctrl_q[DMA0_LSB +: CODE_W];
  assign code_arr[SRC_DMA1] = ctrl_q[DMA1_LSB +: CODE_W];
  assign code_arr[SRC_HOST] = ctrl_q[HOST_LSB +: CODE_W];
  assign req_arr[SRC_EXT]   = ext_req;
  assign req_arr[SRC_DMA0]  = dma0_req;
  assign req_arr[SRC_DMA1]  = dma1_req;
  assign req_arr[SRC_HOST]  = host_req;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    irq_src_decode u_dec (
      .code(code_arr[s]), .req(req_arr[s]), .pend(pend_arr[s]), .lvl(lvl_arr[s])
    );
  end

  assign ext_pend  = pend_arr[SRC_EXT];
  assign ext_lvl   = lvl_arr[SRC_EXT];
  assign dma0_pend = pend_arr[SRC_DMA0];
  assign dma0_lvl  = lvl_arr[SRC_DMA0];
  assign dma1_pend = pend_arr[SRC_DMA1];
  assign dma1_lvl  = lvl_arr[SRC_DMA1];
  assign host_pend = pend_arr[SRC_HOST];
  assign host_lvl  = lvl_arr[SRC_HOST];

  always_comb begin
    rd_data             = ctrl_q;
    rd_data[STATUS_BIT] = status_bit;
  end
endmodule

// File: rtl/irq_prio_reg_chk.sv
module irq_prio_reg_chk
  import irq_prio_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] rd_data,
  input logic             ext_ack,
  input logic             dma0_req,
  input logic             dma0_pend,
  input logic [LVL_W-1:0] dma0_lvl,
  input logic             ext_pend,
  input logic             sync_n,
  input logic             fall_evt,
  input logic             edge_q,
  input logic             edge_armed
);
  localparam logic [REG_W-1:0] FREE_MASK = ~(storage_mask() | field_mask(STATUS_BIT, 1));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & FREE_MASK) == '0);

  p_dma0_decode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma0_pend |-> (dma0_req && rd_data[DMA0_LSB +: 2] != 2'b00 &&
                   dma0_lvl == rd_data[DMA0_LSB +: 2] - 2'd1));

  p_edge_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_armed && fall_evt) |=> edge_q);

  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_armed && ext_ack && !fall_evt) |=> !edge_q);

  p_disarm_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_armed |=> !edge_q);

  p_level_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[EXT_MODE_BIT] && rd_data[EXT_CODE_LSB +: 2] != 2'b00 && !sync_n) |-> ext_pend);

  p_status_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    edge_armed |-> (rd_data[STATUS_BIT] == edge_q));
endmodule

bind irq_prio_reg irq_prio_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .ext_ack(ext_ack),
  .dma0_req(dma0_req), .dma0_pend(dma0_pend), .dma0_lvl(dma0_lvl),
  .ext_pend(ext_pend), .sync_n(sync_n), .fall_evt(fall_evt),
  .edge_q(edge_q), .edge_armed(edge_armed)
);

// File: tb/test_irq_prio_reg.sv
`timescale 1ns/1ps
module test_irq_prio_reg;
  logic clk = 0, rst_n = 0, wr_en = 0, ext_irq_n = 1, ext_ack = 0;
  logic dma0_req = 0, dma1_req = 0, host_req = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic ext_pend, dma0_pend, dma1_pend, host_pend;
  logic [1:0] ext_lvl, dma0_lvl, dma1_lvl, host_lvl;
  int checks = 0, fails = 0;

  localparam logic [31:0] EDGE_ON  = 32'h0000_01C0; // mode=1, code 11
  localparam logic [31:0] LEVEL_ON = 32'h0000_0040; // mode=0, code 01

  always #5 clk = ~clk;

  irq_prio_reg i_irq_prio_reg (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic steps(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_reset_r1;
    chk("R1 rd", rd_data, 0);
    chk("R1 pend", {ext_pend, dma0_pend, dma1_pend, host_pend}, 0);
    chk("R1 lvl", {ext_lvl, dma0_lvl, dma1_lvl, host_lvl}, 0);
  endtask

  task automatic t_mask_r2_r3;
    wr(32'hFFFF_FFFF);           // edge armed, pin high, latch clear
    chk("R2 all ones", rd_data, 32'h003F_01C0);
    wr(32'h0000_0800);
    chk("R3 write one to status", rd_data, 0);
    ext_irq_n = 0; steps(3);     // level, disabled: status = pin low
    wr(32'h0000_0000);
    chk("R3 write zero to status", rd_data, 32'h0000_0800);
    ext_irq_n = 1; steps(3);
  endtask

  function automatic logic [2:0] model(input logic [1:0] c, input logic rq);
    return (c == 2'b00) ? 3'b000 : {rq, 2'(c - 2'd1)};
  endfunction

  task automatic t_decode_r4_r5;
    for (int c = 0; c < 4; c++) begin
      wr(32'(c) << 16 | 32'(3 - c) << 18 | 32'(c) << 20);
      dma0_req = 1; dma1_req = 1; host_req = 0; steps(1);
      chk("R4 R5 dma0", {dma0_pend, dma0_lvl}, model(2'(c), 1'b1));
      chk("R4 R5 dma1", {dma1_pend, dma1_lvl}, model(2'(3 - c), 1'b1));
      chk("R4 R5 host req low", {host_pend, host_lvl}, model(2'(c), 1'b0));
      host_req = 1; steps(1);
      chk("R4 R5 host", {host_pend, host_lvl}, model(2'(c), 1'b1));
    end
    wr(LEVEL_ON | 32'h80);           // ext code 11
    chk("R4 R5 ext level 2", ext_lvl, 2);
    dma0_req = 0; dma1_req = 0; host_req = 0;
    wr(0);
  endtask

  task automatic t_sync_r6;
    @(negedge clk); ext_irq_n = 0;
    @(negedge clk); chk("R6 after one edge", rd_data[11], 0);
    @(negedge clk); chk("R6 after two edges", rd_data[11], 1);
    ext_irq_n = 1; steps(3);
  endtask

  task automatic t_edge_r7_r8_r11;
    wr(EDGE_ON);
    @(negedge clk); ext_irq_n = 0;
    steps(2); chk("R7 not yet", ext_pend, 0);
    steps(1); chk("R7 set", {ext_pend, rd_data[11]}, 2'b11);
    ext_irq_n = 1; steps(4);
    chk("R11 latch held pin high", rd_data[11], 1);
    chk("R7 held", ext_pend, 1);
    ext_ack = 1; steps(1); ext_ack = 0;
    chk("R8 ack clears", {ext_pend, rd_data[11]}, 2'b00);
    ext_irq_n = 0; steps(6);
    ext_ack = 1; steps(1); ext_ack = 0;
    chk("R11 cleared while pin low", {ext_pend, rd_data[11]}, 2'b00);
    ext_irq_n = 1; steps(3);
  endtask

  task automatic t_level_r8_r10;
    wr(LEVEL_ON);
    chk("R10 pin high", {ext_pend, rd_data[11]}, 2'b00);
    ext_irq_n = 0; steps(3);
    chk("R10 pin low", {ext_pend, rd_data[11], ext_lvl}, 4'b1100);
    ext_ack = 1; steps(1); ext_ack = 0;
    chk("R8 ack ignored in level", ext_pend, 1);
    wr(0);
    chk("R10 disabled", {ext_pend, rd_data[11]}, 2'b01);
    ext_irq_n = 1; steps(3);
  endtask

  task automatic t_disarm_r9;
    wr(EDGE_ON);
    ext_irq_n = 0; steps(4); ext_irq_n = 1; steps(3);
    chk("R9 latched", ext_pend, 1);
    wr(32'h0000_0100);           // code 00, mode still edge
    steps(1);
    wr(EDGE_ON); steps(1);
    chk("R9 cleared by disable", {ext_pend, rd_data[11]}, 2'b00);
    ext_irq_n = 0; steps(4); ext_irq_n = 1; steps(3);
    chk("R9 latched again", ext_pend, 1);
    wr(LEVEL_ON); steps(1);
    wr(EDGE_ON); steps(1);
    chk("R9 cleared by level mode", {ext_pend, rd_data[11]}, 2'b00);
  endtask

  initial begin
    steps(2); rst_n = 1; steps(1);
    t_reset_r1;
    t_mask_r2_r3;
    t_decode_r4_r5;
    t_sync_r6;
    t_edge_r7_r8_r11;
    t_level_r8_r10;
    t_disarm_r9;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule